// File: doc/BRIEF.md
# DSP Data Address Generator

This block turns one operand-addressing request of an accumulator-style DSP into a 23-bit data address. The request selects one of eight addressing modes. Two modes take the address from the instruction, either as a full 23-bit value or as a 16-bit value placed under a 7-bit high page register. Two modes add an instruction offset to a 16-bit data page pointer or stack pointer. One mode reaches a separate I/O space through a peripheral page pointer. Three modes use an auxiliary pointer picked from a file of eight.

For the auxiliary-pointer modes the block also returns the updated pointer value, its register index and a write strobe, so the surrounding register file can store it. The update is either a plain increment or a circular increment that stays inside a buffer described by a start and a size. The register file and the memories sit outside the block.

A request is sampled on the clock edge where `in_valid` is high. All results appear one cycle later and stay put until the next accepted request.

Top module: `dsp_agen`

## Requirements
- R1: Mode code 0 (short absolute) gives the address {page_hi, imm[15:0]}.
- R2: Mode code 1 (long absolute) gives the address imm[22:0] unchanged.
- R3: Mode code 2 (page direct) gives {page_hi, (dpage_ptr + imm[15:0]) mod 2^16}. A carry out of the 16-bit sum never reaches the high page bits.
- R4: Mode code 3 (stack direct) gives {stack_hi, (stack_ptr + imm[15:0]) mod 2^16}, with the same no-carry rule.
- R5: Mode code 4 (I/O page) gives the 16-bit I/O address {io_page, imm[6:0]}, with io_page in bits 15:7 and bits 22:16 zero.
- R6: `io_space` is 1 after a request in mode 4 and 0 after a request in any other mode.
- R7: Mode code 5 (indirect) gives {page_hi, ar_val} and raises no write strobe.
- R8: Mode code 6 (indirect, post-increment) gives {page_hi, ar_val} and returns ar_next = (ar_val + 1) mod 2^16.
- R9: Mode code 7 (indirect, circular) gives {page_hi, ar_val} and returns ar_val + 1. When that value equals (circ_base + circ_len) mod 2^16, it returns circ_base instead.
- R10: `ar_we` is 1 only in the cycle after an accepted request in mode 6 or 7. `ar_wb_idx` then equals the request's `ar_idx`.
- R11: Outputs follow an accepted request by exactly one clock. `out_valid` mirrors the previous cycle's `in_valid`. Reset clears `out_valid`, `ar_we`, `io_space` and `addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing mode code 0..7 |
| page_hi | input | 7 | High bits of data page addresses |
| stack_hi | input | 7 | High bits of stack addresses |
| dpage_ptr | input | 16 | Data page pointer |
| stack_ptr | input | 16 | Stack pointer |
| io_page | input | 9 | Peripheral page pointer |
| imm | input | 23 | Instruction offset or absolute address field |
| ar_idx | input | 3 | Index of the selected auxiliary pointer |
| ar_val | input | 16 | Value of the selected auxiliary pointer |
| circ_base | input | 16 | Circular buffer start |
| circ_len | input | 16 | Circular buffer size |
| out_valid | output | 1 | Result of a request is on the outputs |
| addr | output | 23 | Generated data or I/O address |
| io_space | output | 1 | Address targets the I/O space |
| ar_next | output | 16 | Updated auxiliary pointer value |
| ar_we | output | 1 | Write strobe for the updated pointer |
| ar_wb_idx | output | 3 | Index to write the updated pointer to |

## Verification
The circular-buffer assertion assumes two things about a circular request. The pointer already lies in the buffer, meaning (ar_val - circ_base) mod 2^16 < circ_len, and the size is at least 1. Under those conditions the updated pointer is checked to stay in the buffer. The bench builds every circular request from a start, a size from 1 to 5, and a position inside that buffer, so it never leaves this domain. That includes a buffer that straddles the 16-bit wrap point. The other assertions assume nothing beyond a known mode code in each accepted request. The bench only drives codes 0 to 7 while `in_valid` is high.

// File: rtl/agen_pkg.sv
`timescale 1ns/1ps
package agen_pkg;
  typedef enum logic [2:0] {
    AM_ABS16    = 3'd0,
    AM_ABS23    = 3'd1,
    AM_PAGE     = 3'd2,
    AM_STACK    = 3'd3,
    AM_IOPG     = 3'd4,
    AM_IND      = 3'd5,
    AM_IND_INC  = 3'd6,
    AM_IND_CIRC = 3'd7
  } agen_mode_e;

  function automatic logic is_indirect(input agen_mode_e m);
    return (m == AM_IND) || (m == AM_IND_INC) || (m == AM_IND_CIRC);
  endfunction
endpackage

// File: rtl/agen_rst_sync.sv
`timescale 1ns/1ps
module agen_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/agen_direct.sv
`timescale 1ns/1ps
module agen_direct
  import agen_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int PTR_W  = 16,
  parameter int IOPG_W = 9
) (
  input  agen_mode_e              mode,
  input  logic [ADDR_W-PTR_W-1:0] page_hi,
  input  logic [ADDR_W-PTR_W-1:0] stack_hi,
  input  logic [PTR_W-1:0]        dpage_ptr,
  input  logic [PTR_W-1:0]        stack_ptr,
  input  logic [IOPG_W-1:0]       io_page,
  input  logic [ADDR_W-1:0]       imm,
  output logic [ADDR_W-1:0]       addr,
  output logic                    io_space
);
  localparam int HI_W    = ADDR_W - PTR_W;
  localparam int IOOFF_W = PTR_W - IOPG_W;

  logic [PTR_W-1:0] short_off;
  logic [PTR_W-1:0] page_sum;
  logic [PTR_W-1:0] stack_sum;
  logic [PTR_W-1:0] io_addr;

  // 16-bit sums drop their carry so the page bits are never disturbed
  always_comb begin
    short_off = imm[PTR_W-1:0];
    page_sum  = dpage_ptr + short_off;
    stack_sum = stack_ptr + short_off;
    io_addr   = {io_page, imm[IOOFF_W-1:0]};
  end

  always_comb begin
    addr     = '0;
    io_space = 1'b0;
    unique case (mode)
      AM_ABS16: addr = {page_hi, short_off};
      AM_ABS23: addr = imm;
      AM_PAGE:  addr = {page_hi, page_sum};
      AM_STACK: addr = {stack_hi, stack_sum};
      AM_IOPG: begin
        addr     = {{HI_W{1'b0}}, io_addr};
        io_space = 1'b1;
      end
      default:  addr = '0;
    endcase
  end
endmodule

// File: rtl/agen_indirect.sv
`timescale 1ns/1ps
module agen_indirect
  import agen_pkg::*;
#(
  parameter int ADDR_W  = 23,
  parameter int PTR_W   = 16,
  parameter bit CIRC_EN = 1'b1
) (
  input  agen_mode_e              mode,
  input  logic [ADDR_W-PTR_W-1:0] page_hi,
  input  logic [PTR_W-1:0]        ar_val,
  input  logic [PTR_W-1:0]        circ_base,
  input  logic [PTR_W-1:0]        circ_len,
  output logic [ADDR_W-1:0]       addr,
  output logic [PTR_W-1:0]        ar_next,
  output logic                    ar_upd
);
  logic [PTR_W-1:0] bumped;
  logic             circ_wrap;

  assign addr   = {page_hi, ar_val};
  assign bumped = ar_val + PTR_W'(1);
  assign ar_upd = (mode == AM_IND_INC) || (mode == AM_IND_CIRC);

  generate
    if (CIRC_EN) begin : g_circ
      logic [PTR_W-1:0] buf_end;
      assign buf_end   = circ_base + circ_len;
      assign circ_wrap = (mode == AM_IND_CIRC) && (bumped == buf_end);
    end else begin : g_linear
      logic unused_circ;
      assign unused_circ = ^{circ_base, circ_len};
      assign circ_wrap   = 1'b0;
    end
  endgenerate

  always_comb begin
    if (circ_wrap) ar_next = circ_base;
    else           ar_next = bumped;
  end
endmodule

// File: rtl/dsp_agen.sv
`timescale 1ns/1ps
module dsp_agen
  import agen_pkg::*;
#(
  parameter int ADDR_W      = 23,
  parameter int PTR_W       = 16,
  parameter int IOPG_W      = 9,
  parameter int NUM_AR      = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit CIRC_EN     = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [2:0]                 mode,
  input  logic [ADDR_W-PTR_W-1:0]    page_hi,
  input  logic [ADDR_W-PTR_W-1:0]    stack_hi,
  input  logic [PTR_W-1:0]           dpage_ptr,
  input  logic [PTR_W-1:0]           stack_ptr,
  input  logic [IOPG_W-1:0]          io_page,
  input  logic [ADDR_W-1:0]          imm,
  input  logic [$clog2(NUM_AR)-1:0]  ar_idx,
  input  logic [PTR_W-1:0]           ar_val,
  input  logic [PTR_W-1:0]           circ_base,
  input  logic [PTR_W-1:0]           circ_len,
  output logic                       out_valid,
  output logic [ADDR_W-1:0]          addr,
  output logic                       io_space,
  output logic [PTR_W-1:0]           ar_next,
  output logic                       ar_we,
  output logic [$clog2(NUM_AR)-1:0]  ar_wb_idx
);
  localparam int IDX_W = $clog2(NUM_AR);

  agen_mode_e mode_e;
  logic       rst_sync_n;

  logic [ADDR_W-1:0] dir_addr, ind_addr;
  logic              dir_io;
  logic [PTR_W-1:0]  ind_next;
  logic              ind_upd;

  logic [ADDR_W-1:0] addr_d,  addr_q;
  logic              io_d,    io_q;
  logic [PTR_W-1:0]  next_d,  next_q;
  logic [IDX_W-1:0]  idx_d,   idx_q;
  logic              we_d,    we_q;
  logic              vld_d,   vld_q;

  assign mode_e = agen_mode_e'(mode);

  agen_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  agen_direct #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .IOPG_W(IOPG_W)) u_dir (
    .mode      (mode_e),
    .page_hi   (page_hi),
    .stack_hi  (stack_hi),
    .dpage_ptr (dpage_ptr),
    .stack_ptr (stack_ptr),
    .io_page   (io_page),
    .imm       (imm),
    .addr      (dir_addr),
    .io_space  (dir_io)
  );

  agen_indirect #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .CIRC_EN(CIRC_EN)) u_ind (
    .mode      (mode_e),
    .page_hi   (page_hi),
    .ar_val    (ar_val),
    .circ_base (circ_base),
    .circ_len  (circ_len),
    .addr      (ind_addr),
    .ar_next   (ind_next),
    .ar_upd    (ind_upd)
  );

  // next-state
  always_comb begin
    vld_d  = in_valid;
    we_d   = in_valid & ind_upd;
    addr_d = is_indirect(mode_e) ? ind_addr : dir_addr;
    io_d   = dir_io;
    next_d = ind_next;
    idx_d  = ar_idx;
  end

  // control registers: update every cycle
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      we_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      we_q  <= we_d;
    end
  end

  // data registers: clock-enabled by an accepted request
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q <= '0;
      io_q   <= 1'b0;
      next_q <= '0;
      idx_q  <= '0;
    end else if (in_valid) begin
      addr_q <= addr_d;
      io_q   <= io_d;
      next_q <= next_d;
      idx_q  <= idx_d;
    end
  end

  assign out_valid = vld_q;
  assign addr      = addr_q;
  assign io_space  = io_q;
  assign ar_next   = next_q;
  assign ar_we     = we_q;
  assign ar_wb_idx = idx_q;
endmodule

// File: rtl/agen_chk.sv
`timescale 1ns/1ps
module agen_chk #(
  parameter int ADDR_W = 23,
  parameter int PTR_W  = 16,
  parameter int IOPG_W = 9,
  parameter int IDX_W  = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [2:0]              mode,
  input logic [ADDR_W-PTR_W-1:0] page_hi,
  input logic [PTR_W-1:0]        dpage_ptr,
  input logic [ADDR_W-1:0]       imm,
  input logic [IDX_W-1:0]        ar_idx,
  input logic [PTR_W-1:0]        ar_val,
  input logic [PTR_W-1:0]        circ_base,
  input logic [PTR_W-1:0]        circ_len,
  input logic                    out_valid,
  input logic [ADDR_W-1:0]       addr,
  input logic                    io_space,
  input logic [PTR_W-1:0]        ar_next,
  input logic                    ar_we,
  input logic [IDX_W-1:0]        ar_wb_idx
);
  localparam int HI_W = ADDR_W - PTR_W;

  logic circ_ok_in;
  logic [PTR_W-1:0] next_rel;
  assign circ_ok_in = (PTR_W'(ar_val - circ_base) < circ_len) && (circ_len != '0);
  assign next_rel   = ar_next - circ_base;

  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !ar_we);
  p_io_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (io_space == ($past(mode) == 3'd4)));
  p_io_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    io_space |-> (addr[ADDR_W-1:PTR_W] == '0));
  p_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 3'd2) |=>
      (addr == {$past(page_hi), PTR_W'($past(dpage_ptr) + $past(imm[PTR_W-1:0]))}));
  p_we_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (ar_we == ($past(mode) == 3'd6 || $past(mode) == 3'd7)));
  p_wb_idx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (ar_wb_idx == $past(ar_idx)));
  p_circ_stay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 3'd7 && circ_ok_in) |=>
      (PTR_W'(ar_next - $past(circ_base)) < $past(circ_len)));
  p_plain_ind_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 3'd5) |=> !ar_we && (addr[PTR_W-1:0] == $past(ar_val)));

  logic unused_hi;
  assign unused_hi = ^{next_rel, HI_W[0]};
endmodule

bind dsp_agen agen_chk #(
  .ADDR_W (ADDR_W),
  .PTR_W  (PTR_W),
  .IOPG_W (IOPG_W),
  .IDX_W  ($clog2(NUM_AR))
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .mode      (mode),
  .page_hi   (page_hi),
  .dpage_ptr (dpage_ptr),
  .imm       (imm),
  .ar_idx    (ar_idx),
  .ar_val    (ar_val),
  .circ_base (circ_base),
  .circ_len  (circ_len),
  .out_valid (out_valid),
  .addr      (addr),
  .io_space  (io_space),
  .ar_next   (ar_next),
  .ar_we     (ar_we),
  .ar_wb_idx (ar_wb_idx)
);

// File: tb/sim_dsp_agen.sv
`timescale 1ns/1ps
module sim_dsp_agen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  mode;
  logic [6:0]  page_hi, stack_hi;
  logic [15:0] dpage_ptr, stack_ptr;
  logic [8:0]  io_page;
  logic [22:0] imm;
  logic [2:0]  ar_idx;
  logic [15:0] ar_val, circ_base, circ_len;
  logic        out_valid, io_space, ar_we;
  logic [22:0] addr;
  logic [15:0] ar_next;
  logic [2:0]  ar_wb_idx;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  dsp_agen u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .page_hi(page_hi), .stack_hi(stack_hi), .dpage_ptr(dpage_ptr),
    .stack_ptr(stack_ptr), .io_page(io_page), .imm(imm), .ar_idx(ar_idx),
    .ar_val(ar_val), .circ_base(circ_base), .circ_len(circ_len),
    .out_valid(out_valid), .addr(addr), .io_space(io_space),
    .ar_next(ar_next), .ar_we(ar_we), .ar_wb_idx(ar_wb_idx)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge capture, look at the next falling edge
  task automatic issue(input logic [2:0] m);
    mode     = m;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; mode = '0; page_hi = '0; stack_hi = '0;
    dpage_ptr = '0; stack_ptr = '0; io_page = '0; imm = '0; ar_idx = '0;
    ar_val = '0; circ_base = '0; circ_len = 16'd1;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset out_valid", 32'(out_valid), 0);
    check("R11 reset ar_we",     32'(ar_we),     0);
    check("R11 reset io_space",  32'(io_space),  0);
    check("R11 reset addr",      32'(addr),      0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 and R2: absolute modes
    for (int i = 0; i < 8; i++) begin
      page_hi = 7'(i * 17 + 3);
      imm     = 23'(i * 32'h0F1E2D + 32'h7FFF80);
      issue(3'd0);
      check("R1 short absolute", 32'(addr), (32'(page_hi) << 16) | (32'(imm) & 32'hFFFF));
      check("R11 out_valid",     32'(out_valid), 1);
      issue(3'd1);
      check("R2 long absolute",  32'(addr), 32'(imm));
    end

    // R3, R4, R6: direct modes incl. 16-bit wrap
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        page_hi   = 7'h40 + 7'(i);
        stack_hi  = 7'h11 + 7'(j);
        dpage_ptr = 16'(i * 32'h1111);
        stack_ptr = 16'(j * 32'h1111);
        imm       = 23'(32'h550000 + j * 32'h1111);
        issue(3'd2);
        check("R3 page direct", 32'(addr),
              (32'(page_hi) << 16) | ((32'(dpage_ptr) + (32'(imm) & 32'hFFFF)) % 32'h10000));
        check("R6 no io in page", 32'(io_space), 0);
        issue(3'd3);
        check("R4 stack direct", 32'(addr),
              (32'(stack_hi) << 16) | ((32'(stack_ptr) + (32'(imm) & 32'hFFFF)) % 32'h10000));
      end
    end
    // R3 worked example: high 0x40, pointer 0x200, offset 5
    page_hi = 7'h40; dpage_ptr = 16'h0200; imm = 23'h5;
    issue(3'd2);
    check("R3 example", 32'(addr), 32'h40_0205);

    // R5, R6: I/O page
    for (int p = 0; p < 512; p += 73) begin
      for (int o = 0; o < 256; o += 45) begin
        io_page = 9'(p); imm = 23'(32'h7FFF00 | o); page_hi = 7'h7F;
        issue(3'd4);
        check("R5 io address", 32'(addr), 32'(p) * 128 + 32'(o % 128));
        check("R6 io flag",    32'(io_space), 1);
        check("R10 no we in io", 32'(ar_we), 0);
      end
    end

    // R7, R8: indirect plain and post-increment
    for (int k = 0; k < 8; k++) begin
      ar_idx = 3'(k); page_hi = 7'(k + 1);
      ar_val = (k == 7) ? 16'hFFFF : 16'(k * 32'h2345);
      issue(3'd5);
      check("R7 indirect addr", 32'(addr), (32'(k + 1) << 16) | 32'(ar_val));
      check("R7 no write",      32'(ar_we), 0);
      check("R6 no io indirect", 32'(io_space), 0);
      issue(3'd6);
      check("R8 post-inc addr",  32'(addr), (32'(k + 1) << 16) | 32'(ar_val));
      check("R8 post-inc value", 32'(ar_next), (32'(ar_val) + 1) % 32'h10000);
      check("R10 we post-inc",   32'(ar_we), 1);
      check("R10 wb index",      32'(ar_wb_idx), 32'(k));
    end

    // R9: circular buffers, including one straddling 0xFFFF
    for (int b = 0; b < 2; b++) begin
      for (int s = 1; s <= 5; s++) begin
        for (int q = 0; q < s; q++) begin
          logic [31:0] st, cur, want;
          st        = (b == 0) ? 32'h0010 : 32'hFFFE;
          cur       = (st + 32'(q)) % 32'h10000;
          want      = (q + 1 == s) ? st : (cur + 1) % 32'h10000;
          circ_base = 16'(st); circ_len = 16'(s); ar_val = 16'(cur);
          ar_idx = 3'(q); page_hi = 7'h2A;
          issue(3'd7);
          check("R9 circular next", 32'(ar_next), want);
          check("R9 circular addr", 32'(addr), (32'h2A << 16) | cur);
          check("R10 we circular",  32'(ar_we), 1);
        end
      end
    end

    // R10, R11: idle cycle after a write request
    ar_val = 16'h1234;
    issue(3'd6);
    @(negedge clk);
    check("R10 we clears when idle", 32'(ar_we), 0);
    check("R11 out_valid idle",      32'(out_valid), 0);
    check("R11 addr held idle",      32'(addr), (32'h2A << 16) | 32'h1234);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule